// File: doc/BRIEF.md
# Two-Wire Debug Bus Frame Monitor

This block listens, without ever driving, to a half-duplex debug link built from a host-driven clock line and a shared data line. A fast system clock samples both lines through synchronizers and finds their edges. A long low interval on the clock line resynchronizes the monitor. The monitor then follows each frame field by field: a start pulse, a 2-bit operation code, and then the body that belongs to that operation. It emits one strobe per completed frame, carrying the operation, the byte count, the assembled data word and the address byte.

The controller has these states. `ST_HUNT` is entered after system reset and is left only on a bus reset. `ST_IDLE` waits for the start pulse. `ST_OPC` collects the operation code. `ST_RLEN` and `ST_WLEN` collect the length field. `ST_RWAIT` and `ST_WWAIT` poll the wait handshake. `ST_RBYTE` and `ST_WBYTE` collect data bytes. `ST_TURN` skips one turnaround edge. `ST_ARD` and `ST_AWR` collect the address byte. `ST_STOP` consumes the closing edge.

The transitions are:
- HUNT→IDLE on a bus reset.
- IDLE→OPC on a rising edge.
- OPC→RLEN, WLEN, TURN or AWR for codes 0, 1, 2 and 3, on the second rising edge.
- RLEN→RWAIT on the last length bit.
- RWAIT→RBYTE on a falling edge that sees data high.
- RBYTE→STOP after the last bit of the last byte.
- WLEN→WBYTE on the last length bit.
- WBYTE→WWAIT after the last bit of the last byte.
- WWAIT→STOP on a falling edge that sees data high.
- TURN→ARD on a falling edge.
- ARD→STOP and AWR→STOP after eight bits.
- STOP→IDLE on a rising edge, which also emits the frame.
- Any state→IDLE on a bus reset.

Top module: `twd_monitor`

## Requirements
- R1: After system reset, every frame output is zero. Bus activity produces no frame until the first bus reset has been seen.
- R2: A bus reset occurs when the synchronized clock line has been low for at least `LOW_RESET_CYCLES` samples and then rises. It returns the monitor to awaiting a start from any state. A partly received frame is dropped and never reported.
- R3: After a bus reset or a finished frame, the rising edge that ends the next short low pulse is the start. The next two rising edges carry the operation code, least significant bit first. The codes are: 0 data read, 1 data write, 2 address read, 3 address write.
- R4: In an address write, eight bits are taken on rising edges, least significant bit first. One more rising edge then closes the frame. The frame reports code 3, count 0, the byte on `frame_addr` and zero on `frame_data`.
- R5: In an address read, the first falling edge after the code is a turnaround and carries no bit. Eight bits are then taken on falling edges, least significant bit first, and the next rising edge closes the frame. The frame reports code 2 and count 0.
- R6: Data frames carry a 2-bit length field on rising edges, least significant bit first. The reported byte count is the field value plus one, so it lies between 1 and 4.
- R7: In a data write, the bytes follow the length field on rising edges. After them, each falling edge samples the data line until it is seen high. The following rising edge then closes the frame.
- R8: In a data read, each falling edge after the length field samples the data line until it is seen high. The bytes are then taken on the falling edges that follow.
- R9: Byte k of a data frame (k counted from 0) appears in `frame_data[8k+7:8k]`. Bytes beyond the count read as zero.
- R10: `frame_valid` is high for exactly one system cycle per frame. The frame fields keep their values until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ck | input | 1 | Debug bus clock line (asynchronous) |
| bus_d | input | 1 | Debug bus data line (asynchronous) |
| frame_valid | output | 1 | One-cycle strobe for a completed frame |
| frame_op | output | 2 | Operation code of the frame |
| frame_count | output | LEN_W+1 | Data byte count, 0 for address frames |
| frame_data | output | 8*2^LEN_W | Assembled data bytes |
| frame_addr | output | 8 | Address byte of address frames |

## Verification
The monitor is exercised with all four operation codes. Data frames use one, three and four bytes, so the count arithmetic and the byte placement are each exposed. Wait phases of zero and of several low polls show whether the monitor samples the handshake on the correct edge and stays put while the line is low. Address reads use a byte whose bit pattern would shift if the turnaround edge were taken as data. A frame sent before any bus reset, a reset issued halfway through a data write, and two back-to-back resets separate the resynchronization paths from normal frame decoding.

// File: rtl/twd_pkg.sv
package twd_pkg;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_IDLE,
        ST_OPC,
        ST_RLEN,
        ST_WLEN,
        ST_RWAIT,
        ST_RBYTE,
        ST_WBYTE,
        ST_WWAIT,
        ST_TURN,
        ST_ARD,
        ST_AWR,
        ST_STOP
    } mon_state_e;

    typedef enum logic [1:0] {
        OP_DATA_RD = 2'd0,
        OP_DATA_WR = 2'd1,
        OP_ADDR_RD = 2'd2,
        OP_ADDR_WR = 2'd3
    } op_e;

endpackage

// File: rtl/twd_sync.sv
module twd_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/twd_clk_watch.sv
module twd_clk_watch #(
    parameter int LOW_RESET_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_s,
    output logic rise,
    output logic fall,
    output logic bus_rst
);

    localparam int CW = $clog2(LOW_RESET_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOW_RESET_CYCLES);

    logic          ck_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q    <= 1'b0;
            low_cnt <= '0;
        end else begin
            ck_q <= ck_s;
            if (ck_s)                 low_cnt <= '0;
            else if (low_cnt != LIMIT) low_cnt <= low_cnt + CW'(1);
        end
    end

    assign rise    = ck_s & ~ck_q;
    assign fall    = ~ck_s & ck_q;
    assign bus_rst = rise && (low_cnt == LIMIT);

    // R2: a bus reset is only recognised at the end of a low interval
    assert_reset_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |-> $past(ck_s == 1'b0));

endmodule

// File: rtl/twd_monitor.sv
module twd_monitor
    import twd_pkg::*;
#(
    parameter int LOW_RESET_CYCLES = 2000,
    parameter int SYNC_STAGES      = 2,
    parameter int LEN_W            = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_ck,
    input  logic                        bus_d,
    output logic                        frame_valid,
    output logic [1:0]                  frame_op,
    output logic [LEN_W:0]              frame_count,
    output logic [8*(1<<LEN_W)-1:0]     frame_data,
    output logic [7:0]                  frame_addr
);

    localparam int MAX_BYTES = 1 << LEN_W;
    localparam int DATA_W    = 8 * MAX_BYTES;
    localparam int CNT_W     = LEN_W + 1;

    logic [1:0] lines_s;
    logic       ck_s, d_s;
    logic       rise, fall, bus_rst;

    twd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_ck, bus_d}),
        .dout (lines_s)
    );

    assign ck_s = lines_s[1];
    assign d_s  = lines_s[0];

    twd_clk_watch #(.LOW_RESET_CYCLES(LOW_RESET_CYCLES)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ck_s   (ck_s),
        .rise   (rise),
        .fall   (fall),
        .bus_rst(bus_rst)
    );

    mon_state_e         state, nxt;
    logic [2:0]         bit_cnt;
    logic [7:0]         shift_q, nb;
    logic [1:0]         op_q, op_new;
    logic [LEN_W-1:0]   len_q, len_new, byte_idx;
    logic [DATA_W-1:0]  pay_q;
    logic [7:0]         addr_q;
    logic               last_bit, last_byte, shift_en;

    assign nb        = {d_s, shift_q[7:1]};
    assign op_new    = nb[7:6];
    assign len_new   = nb[7 -: LEN_W];
    assign last_bit  = (bit_cnt == 3'd7);
    assign last_byte = (byte_idx == len_q);

    always_comb begin
        shift_en = 1'b0;
        case (state)
            ST_OPC, ST_RLEN, ST_WLEN, ST_WBYTE, ST_AWR: shift_en = rise;
            ST_RBYTE, ST_ARD:                           shift_en = fall;
            default:                                    shift_en = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:  nxt = ST_HUNT;
            ST_IDLE:  if (rise) nxt = ST_OPC;
            ST_OPC:   if (rise && bit_cnt == 3'd1) begin
                          unique case (op_e'(op_new))
                              OP_DATA_RD: nxt = ST_RLEN;
                              OP_DATA_WR: nxt = ST_WLEN;
                              OP_ADDR_RD: nxt = ST_TURN;
                              OP_ADDR_WR: nxt = ST_AWR;
                          endcase
                      end
            ST_RLEN:  if (rise && bit_cnt == 3'(LEN_W-1)) nxt = ST_RWAIT;
            ST_WLEN:  if (rise && bit_cnt == 3'(LEN_W-1)) nxt = ST_WBYTE;
            ST_RWAIT: if (fall && d_s) nxt = ST_RBYTE;
            ST_RBYTE: if (fall && last_bit && last_byte) nxt = ST_STOP;
            ST_WBYTE: if (rise && last_bit && last_byte) nxt = ST_WWAIT;
            ST_WWAIT: if (fall && d_s) nxt = ST_STOP;
            ST_TURN:  if (fall) nxt = ST_ARD;
            ST_ARD:   if (fall && last_bit) nxt = ST_STOP;
            ST_AWR:   if (rise && last_bit) nxt = ST_STOP;
            ST_STOP:  if (rise) nxt = ST_IDLE;
        endcase
        if (bus_rst) nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            shift_q     <= '0;
            op_q        <= '0;
            len_q       <= '0;
            byte_idx    <= '0;
            pay_q       <= '0;
            addr_q      <= '0;
            frame_valid <= 1'b0;
            frame_op    <= '0;
            frame_count <= '0;
            frame_data  <= '0;
            frame_addr  <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (bus_rst) begin
                bit_cnt <= '0;
            end else begin
                if (shift_en) begin
                    shift_q <= nb;
                    bit_cnt <= bit_cnt + 3'd1;
                end
                case (state)
                    ST_IDLE: if (rise) begin
                        bit_cnt  <= '0;
                        op_q     <= '0;
                        len_q    <= '0;
                        byte_idx <= '0;
                        pay_q    <= '0;
                        addr_q   <= '0;
                    end
                    ST_OPC: if (rise && bit_cnt == 3'd1) begin
                        op_q    <= op_new;
                        bit_cnt <= '0;
                    end
                    ST_RLEN, ST_WLEN: if (rise && bit_cnt == 3'(LEN_W-1)) begin
                        len_q   <= len_new;
                        bit_cnt <= '0;
                    end
                    ST_WBYTE: if (rise && last_bit) begin
                        pay_q[{byte_idx, 3'b000} +: 8] <= nb;
                        byte_idx <= byte_idx + LEN_W'(1);
                    end
                    ST_RBYTE: if (fall && last_bit) begin
                        pay_q[{byte_idx, 3'b000} +: 8] <= nb;
                        byte_idx <= byte_idx + LEN_W'(1);
                    end
                    ST_AWR: if (rise && last_bit) addr_q <= nb;
                    ST_ARD: if (fall && last_bit) addr_q <= nb;
                    ST_STOP: if (rise) begin
                        frame_valid <= 1'b1;
                        frame_op    <= op_q;
                        frame_count <= op_q[1] ? '0 : CNT_W'(len_q) + CNT_W'(1);
                        frame_data  <= pay_q;
                        frame_addr  <= addr_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: leaving the hunt state is only possible towards idle
    assert_hunt_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |=> (state == ST_HUNT || state == ST_IDLE));

    // R2: a bus reset always lands in idle
    assert_reset_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (state == ST_IDLE));

    // R4, R5: address frames carry no byte count
    assert_addr_count_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_op[1]) |-> (frame_count == '0));

    // R6: data frames report between one and the maximum byte count
    assert_data_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_op[1]) |-> (frame_count != '0 && frame_count <= CNT_W'(MAX_BYTES)));

    // R10: the strobe lasts one cycle and follows the stop phase
    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_strobe_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ($past(state) == ST_STOP));

endmodule

// File: tb/twd_monitor_test.sv
module twd_monitor_test;

    localparam int CLK_PERIOD = 10;
    localparam int LOWRST     = 32;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ck = 1'b1;
    logic        bus_d = 1'b0;
    logic        frame_valid;
    logic [1:0]  frame_op;
    logic [2:0]  frame_count;
    logic [31:0] frame_data;
    logic [7:0]  frame_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int n_frames = 0;
    int n_hi = 0;
    logic fv_q = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twd_monitor #(.LOW_RESET_CYCLES(LOWRST)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_ck     (bus_ck),
        .bus_d      (bus_d),
        .frame_valid(frame_valid),
        .frame_op   (frame_op),
        .frame_count(frame_count),
        .frame_data (frame_data),
        .frame_addr (frame_addr)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) begin
                n_hi = n_hi + 1;
                if (!fv_q) n_frames = n_frames + 1;
            end
            fv_q = frame_valid;
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(logic df, logic dr);
        bus_d = df;
        wait_clk(HALF);
        bus_ck = 1'b0;
        wait_clk(HALF);
        bus_d = dr;
        wait_clk(HALF);
        bus_ck = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic bus_reset();
        bus_d = 1'b0;
        wait_clk(HALF);
        bus_ck = 1'b0;
        wait_clk(LOWRST + 16);
        bus_ck = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic rise_bits(logic [31:0] v, int n);
        for (int i = 0; i < n; i++) pulse(1'b0, v[i]);
    endtask

    task automatic fall_bits(logic [31:0] v, int n);
        for (int i = 0; i < n; i++) pulse(v[i], 1'b0);
    endtask

    task automatic send_addr_write(logic [7:0] a);
        pulse(1'b0, 1'b0);
        rise_bits(32'd3, 2);
        rise_bits({24'd0, a}, 8);
        pulse(1'b0, 1'b0);
    endtask

    task automatic send_addr_read(logic [7:0] a);
        pulse(1'b0, 1'b0);
        rise_bits(32'd2, 2);
        pulse(1'b1, 1'b1);
        fall_bits({24'd0, a}, 8);
    endtask

    task automatic send_data_write(logic [31:0] v, int nb, int nwait);
        pulse(1'b0, 1'b0);
        rise_bits(32'd1, 2);
        rise_bits(32'(nb - 1), 2);
        rise_bits(v, nb * 8);
        repeat (nwait) pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
    endtask

    task automatic send_data_read(logic [31:0] v, int nb, int nwait);
        pulse(1'b0, 1'b0);
        rise_bits(32'd0, 2);
        rise_bits(32'(nb - 1), 2);
        repeat (nwait) pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        fall_bits(v, nb * 8);
    endtask

    task automatic expect_frame(string req, int prev, logic [1:0] op, int cnt,
                                logic [31:0] data, logic [7:0] addr);
        wait_clk(4);
        chk(req, "frame count", n_frames, prev + 1);
        chk(req, "op", {30'd0, frame_op}, {30'd0, op});
        chk(req, "byte count", {29'd0, frame_count}, 32'(cnt));
        chk(req, "data", frame_data, data);
        chk(req, "addr", {24'd0, frame_addr}, {24'd0, addr});
    endtask

    // R1: reset values
    task automatic t_reset_state();
        chk("R1", "valid", {31'd0, frame_valid}, 32'd0);
        chk("R1", "op", {30'd0, frame_op}, 32'd0);
        chk("R1", "count", {29'd0, frame_count}, 32'd0);
        chk("R1", "data", frame_data, 32'd0);
        chk("R1", "addr", {24'd0, frame_addr}, 32'd0);
    endtask

    // R1: a frame before any bus reset is ignored
    task automatic t_before_bus_reset();
        send_addr_write(8'h77);
        wait_clk(8);
        chk("R1", "frames before bus reset", n_frames, 0);
        chk("R1", "addr untouched", {24'd0, frame_addr}, 32'd0);
    endtask

    // R3, R4: address write
    task automatic t_addr_write();
        int p = n_frames;
        send_addr_write(8'hA5);
        expect_frame("R4", p, 2'd3, 0, 32'd0, 8'hA5);
    endtask

    // R3, R5: address read with turnaround edge skipped
    task automatic t_addr_read();
        int p = n_frames;
        send_addr_read(8'h3C);
        expect_frame("R5", p, 2'd2, 0, 32'd0, 8'h3C);
    endtask

    // R6, R7: single-byte write, no wait
    task automatic t_write_single();
        int p = n_frames;
        send_data_write(32'h0000005A, 1, 0);
        expect_frame("R7", p, 2'd1, 1, 32'h0000005A, 8'h00);
    endtask

    // R6, R7, R9: four-byte write with wait polls
    task automatic t_write_full();
        int p = n_frames;
        send_data_write(32'hDEADBEEF, 4, 2);
        expect_frame("R9", p, 2'd1, 4, 32'hDEADBEEF, 8'h00);
    endtask

    // R8, R9: three-byte read after wait polls, top byte zero
    task automatic t_read_three();
        int p = n_frames;
        send_data_read(32'h00A1B2C3, 3, 3);
        expect_frame("R8", p, 2'd0, 3, 32'h00A1B2C3, 8'h00);
    endtask

    // R8: one-byte read, wait satisfied at once
    task automatic t_read_one();
        int p = n_frames;
        send_data_read(32'h00000081, 1, 0);
        expect_frame("R8", p, 2'd0, 1, 32'h00000081, 8'h00);
    endtask

    // R2: bus reset in the middle of a data write, then back-to-back resets
    task automatic t_reset_mid();
        int p = n_frames;
        pulse(1'b0, 1'b0);
        rise_bits(32'd1, 2);
        rise_bits(32'd3, 2);
        rise_bits(32'h12, 5);
        bus_reset();
        wait_clk(4);
        chk("R2", "aborted frame not reported", n_frames, p);
        bus_reset();
        send_addr_write(8'hC3);
        expect_frame("R2", p, 2'd3, 0, 32'd0, 8'hC3);
    endtask

    // R10: fields hold after the strobe, strobe lasts one cycle
    task automatic t_hold();
        wait_clk(40);
        chk("R10", "valid low after frame", {31'd0, frame_valid}, 32'd0);
        chk("R10", "addr held", {24'd0, frame_addr}, 32'hC3);
        chk("R10", "op held", {30'd0, frame_op}, 32'd3);
        chk("R10", "strobe cycles per frame", n_hi, n_frames);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset_state();
        t_before_bus_reset();
        bus_reset();
        t_addr_write();
        t_addr_read();
        t_write_single();
        t_write_full();
        t_read_three();
        t_read_one();
        t_reset_mid();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule